// File: doc/BRIEF.md
# Dynamic-Capable Memory Access Sequencer

This block sits between a processing datapath and a set of single-port RAM banks. It produces memory commands and addresses on its own, so the datapath only supplies write words and consumes read words. A built-in program supplies one slot per executed cycle. Each slot names a command (idle, read or write), an address source (a static counter, a dynamic address register, or a held base address), a condition-enable flag, a counter-rewind flag and an address-ALU operation.

Conditional slots issue their command only if a condition flag is set. The datapath loads that flag through bit 0 of its data word. Dynamic slots take their address from a small address-width ALU. The datapath hands this ALU one base address, and the ALU then walks a two-row block around that base. Every logical address passes through a 16-entry translation table, which picks one of four banks and a physical address. Only the selected bank sees the command.

Top module: `mem_access_seq`

## Requirements
- R1: While `rst_n` is low, and after it is released until `start` is seen, `bank_act`, `rd_valid`, `stall` and `done` are all 0.
- R2: The cycle after a `start` pulse runs program slot 0. `start` clears the slot pointer, the static counter, the dynamic address register, the condition flag and the held-base flag, so a flag left set by an earlier run has no effect on the new run.
- R3: A static slot uses the static counter as its logical address. The counter starts at 0, and each executed static slot adds 1, or returns it to 0 when the slot's rewind flag is set. A write stores the `dp_wdata` value present in the cycle the slot executes.
- R4: The translation index is the logical address bits [9:6]. The bank is the index mod 4, and the physical address is (index div 4) * 64 + address bits [5:0]. In the cycle a command issues, `bank_act` has bit b set for bank b and no other bit set.
- R5: A pulse on `cond_ld` stores `dp_wdata[0]` in the condition flag. A slot with condition-enable set and the flag at 0 issues no command: `bank_act` stays 0, no `rd_valid` follows, and the program still advances.
- R6: A read returns its word on `rd_data`, with `rd_valid` high, exactly one cycle after the cycle it is issued.
- R7: The address ALU updates the dynamic register only in a cycle where a slot executes, using the address of that slot. The operations are: +1, -1, + row stride (64), shift left by one, load the held base, or keep the value. All results wrap modulo 1024.
- R8: A slot that takes the held base while no base is held raises `stall` and holds `bank_act` at 0. The program does not advance during the stall. A `base_valid` pulse stores `base_in`, and the stalled slot runs in the next cycle. Executing a base-sourced slot uses up the held base.
- R9: `done` is high for exactly one cycle: the cycle after the last slot executes. After that no command issues until the next `start`.
- R10: The built-in program has 17 slots. Slots 0–3 are static writes. Slots 4–7 are static reads. Slots 2 and 6 are conditional. Slots 3 and 7 rewind the counter. Slot 8 writes at the base, then applies +1. Slots 9, 10 and 11 are dynamic writes, followed by +stride, -1 and load-base. Slots 12, 13, 14 and 15 are dynamic reads, followed by +1, +stride, -1 and shift. Slot 16 is a conditional dynamic read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Restart the program from slot 0 |
| dp_wdata | input | 16 | Datapath word: write data, and the condition value in bit 0 |
| cond_ld | input | 1 | Load `dp_wdata[0]` into the condition flag |
| base_in | input | 10 | Base logical address for dynamic block accesses |
| base_valid | input | 1 | Store `base_in` as the held base |
| bank_act | output | 4 | Per-bank command enable, bit b is bank b |
| stall | output | 1 | Program waiting for a base address |
| done | output | 1 | One-cycle pulse after the last slot |
| rd_valid | output | 1 | Read word present on `rd_data` |
| rd_data | output | 16 | Returned read word |

## Verification
The assertions assume that `start` is not raised while the `stall` wait it would cut short is the condition being checked. That is why the pointer-hold property excludes a start cycle. They also assume that `cond_ld` and `base_valid` are single-cycle strobes driven away from the clock edge. The stimulus raises `start` only once per run, after the previous run's `done`. It pulses `cond_ld` and `base_valid` for exactly one cycle at fixed offsets from `start`. It chooses base addresses whose block walk, including the final shift, lands on locations written earlier in the same run, so every expected read word is defined.

// File: rtl/mas_pkg.sv
package mas_pkg;

   typedef enum logic [1:0] {OP_IDLE = 2'd0, OP_RD = 2'd1, OP_WR = 2'd2} op_e;
   typedef enum logic [1:0] {SRC_STAT = 2'd0, SRC_DYN = 2'd1, SRC_BASE = 2'd2} src_e;
   typedef enum logic [2:0] {
      ALU_NOP  = 3'd0,
      ALU_INC  = 3'd1,
      ALU_DEC  = 3'd2,
      ALU_ADDS = 3'd3,
      ALU_SHL  = 3'd4,
      ALU_LDB  = 3'd5
   } alu_e;

   typedef struct packed {
      op_e  op;
      src_e src;
      logic cond_en;
      logic rewind;
      alu_e alu;
   } slot_t;

   localparam int PROG_LEN = 17;

   // Built-in access program (R10)
   function automatic slot_t prog_slot(input int unsigned idx);
      slot_t s;
      s = '{op: OP_IDLE, src: SRC_STAT, cond_en: 1'b0, rewind: 1'b0, alu: ALU_NOP};
      case (idx)
         0, 1:    s.op = OP_WR;
         2:       begin s.op = OP_WR; s.cond_en = 1'b1; end
         3:       begin s.op = OP_WR; s.rewind = 1'b1; end
         4, 5:    s.op = OP_RD;
         6:       begin s.op = OP_RD; s.cond_en = 1'b1; end
         7:       begin s.op = OP_RD; s.rewind = 1'b1; end
         8:       begin s.op = OP_WR; s.src = SRC_BASE; s.alu = ALU_INC;  end
         9:       begin s.op = OP_WR; s.src = SRC_DYN;  s.alu = ALU_ADDS; end
         10:      begin s.op = OP_WR; s.src = SRC_DYN;  s.alu = ALU_DEC;  end
         11:      begin s.op = OP_WR; s.src = SRC_DYN;  s.alu = ALU_LDB;  end
         12:      begin s.op = OP_RD; s.src = SRC_DYN;  s.alu = ALU_INC;  end
         13:      begin s.op = OP_RD; s.src = SRC_DYN;  s.alu = ALU_ADDS; end
         14:      begin s.op = OP_RD; s.src = SRC_DYN;  s.alu = ALU_DEC;  end
         15:      begin s.op = OP_RD; s.src = SRC_DYN;  s.alu = ALU_SHL;  end
         16:      begin s.op = OP_RD; s.src = SRC_DYN;  s.cond_en = 1'b1; end
         default: ;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/mas_addr_alu.sv
module mas_addr_alu
   import mas_pkg::*;
#(
   parameter int LADDR_W  = 10,
   parameter int STRIDE   = 64,
   parameter bit SHIFT_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear,
   input  logic               step,
   input  alu_e               op,
   input  logic [LADDR_W-1:0] cur_addr,
   input  logic [LADDR_W-1:0] base,
   output logic [LADDR_W-1:0] dyn
);

   localparam logic [LADDR_W-1:0] STRIDE_V = LADDR_W'(STRIDE);

   logic [LADDR_W-1:0] shl_res;
   logic [LADDR_W-1:0] nxt;

   generate
      if (SHIFT_EN) begin : g_shl
         assign shl_res = {cur_addr[LADDR_W-2:0], 1'b0};
      end else begin : g_noshl
         assign shl_res = cur_addr;
      end
   endgenerate

   always_comb begin
      case (op)
         ALU_INC:  nxt = cur_addr + 1'b1;
         ALU_DEC:  nxt = cur_addr - 1'b1;
         ALU_ADDS: nxt = cur_addr + STRIDE_V;
         ALU_SHL:  nxt = shl_res;
         ALU_LDB:  nxt = base;
         default:  nxt = dyn;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     dyn <= '0;
      else if (clear) dyn <= '0;
      else if (step)  dyn <= nxt;
   end

   // R7: register only moves in executed slots
   assert_dyn_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !clear) |=> dyn == $past(dyn));

endmodule

// File: rtl/mas_xlat.sv
module mas_xlat #(
   parameter int LADDR_W    = 10,
   parameter int IDX_W      = 4,
   parameter int NBANK      = 4,
   parameter int BANK_DEPTH = 256,
   localparam int BANK_W    = (NBANK > 1) ? $clog2(NBANK) : 1,
   localparam int PADDR_W   = $clog2(BANK_DEPTH)
) (
   input  logic [LADDR_W-1:0] laddr,
   output logic [BANK_W-1:0]  bank,
   output logic [PADDR_W-1:0] paddr
);

   localparam int OFF_W   = LADDR_W - IDX_W;
   localparam int PAGE    = 2 ** OFF_W;
   localparam int ENTRIES = 2 ** IDX_W;

   generate
      if (ENTRIES % NBANK != 0) begin : g_bad_split
         $error("translation entries must divide evenly over banks");
      end
      if ((ENTRIES / NBANK) * PAGE != BANK_DEPTH) begin : g_bad_fill
         $error("translation pages must exactly fill each bank");
      end
   endgenerate

   logic [BANK_W-1:0]  bank_tab [ENTRIES];
   logic [PADDR_W-1:0] page_tab [ENTRIES];

   generate
      for (genvar i = 0; i < ENTRIES; i++) begin : g_tab
         assign bank_tab[i] = BANK_W'(i % NBANK);
         assign page_tab[i] = PADDR_W'((i / NBANK) * PAGE);
      end
   endgenerate

   logic [IDX_W-1:0] idx;
   logic [OFF_W-1:0] off;

   assign idx   = laddr[LADDR_W-1:OFF_W];
   assign off   = laddr[OFF_W-1:0];
   assign bank  = bank_tab[idx];
   assign paddr = page_tab[idx] + PADDR_W'(off);

endmodule

// File: rtl/mas_bank_array.sv
module mas_bank_array #(
   parameter int NBANK      = 4,
   parameter int BANK_DEPTH = 256,
   parameter int DATA_W     = 16,
   localparam int BANK_W    = (NBANK > 1) ? $clog2(NBANK) : 1,
   localparam int PADDR_W   = $clog2(BANK_DEPTH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               issue,
   input  logic               we,
   input  logic [BANK_W-1:0]  bank,
   input  logic [PADDR_W-1:0] paddr,
   input  logic [DATA_W-1:0]  wdata,
   output logic [NBANK-1:0]   bank_en,
   output logic               rd_valid,
   output logic [DATA_W-1:0]  rd_data
);

   logic [NBANK-1:0][DATA_W-1:0] rd_all;
   logic [BANK_W-1:0]            rd_bank_q;
   logic                         rd_valid_q;

   generate
      for (genvar b = 0; b < NBANK; b++) begin : g_bank
         logic [DATA_W-1:0] mem [BANK_DEPTH];
         logic [DATA_W-1:0] rdq;

         assign bank_en[b] = issue && (bank == BANK_W'(b));

         always_ff @(posedge clk) begin
            if (bank_en[b]) begin
               if (we) mem[paddr] <= wdata;
               else    rdq        <= mem[paddr];
            end
         end

         assign rd_all[b] = rdq;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid_q <= 1'b0;
         rd_bank_q  <= '0;
      end else begin
         rd_valid_q <= issue && !we;
         if (issue && !we) rd_bank_q <= bank;
      end
   end

   assign rd_valid = rd_valid_q;
   assign rd_data  = rd_valid_q ? rd_all[rd_bank_q] : '0;

   // R4: a command reaches at most one bank
   assert_bank_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bank_en));

endmodule

// File: rtl/mas_sched_ctrl.sv
module mas_sched_ctrl
   import mas_pkg::*;
#(
   parameter int LADDR_W = 10,
   parameter int NSLOT   = mas_pkg::PROG_LEN,
   localparam int PTR_W  = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               cond_ld,
   input  logic               cond_bit,
   input  logic [LADDR_W-1:0] base_in,
   input  logic               base_valid,
   input  logic [LADDR_W-1:0] dyn_addr,
   output slot_t              slot,
   output logic               step,
   output logic               issue,
   output logic               issue_we,
   output logic [LADDR_W-1:0] laddr,
   output logic [LADDR_W-1:0] base_q,
   output logic               stall,
   output logic               done
);

   localparam logic [PTR_W-1:0] LAST = PTR_W'(NSLOT - 1);

   logic [PTR_W-1:0]   ptr;
   logic               running;
   logic [LADDR_W-1:0] stc;
   logic               cond_q;
   logic               base_have;
   logic               done_q;
   logic               gated;

   always_comb begin
      slot     = prog_slot(int'(ptr));
      stall    = running && (slot.src == SRC_BASE) && !base_have;
      step     = running && !stall;
      gated    = slot.cond_en && !cond_q;
      issue    = step && (slot.op != OP_IDLE) && !gated;
      issue_we = (slot.op == OP_WR);
      case (slot.src)
         SRC_STAT: laddr = stc;
         SRC_DYN:  laddr = dyn_addr;
         default:  laddr = base_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr       <= '0;
         running   <= 1'b0;
         stc       <= '0;
         cond_q    <= 1'b0;
         base_have <= 1'b0;
         base_q    <= '0;
         done_q    <= 1'b0;
      end else if (start) begin
         ptr       <= '0;
         running   <= 1'b1;
         stc       <= '0;
         cond_q    <= 1'b0;
         base_have <= 1'b0;
         done_q    <= 1'b0;
      end else begin
         done_q <= step && (ptr == LAST);
         if (cond_ld) cond_q <= cond_bit;
         if (step && slot.src == SRC_BASE) base_have <= 1'b0;
         if (base_valid) begin
            base_q    <= base_in;
            base_have <= 1'b1;
         end
         if (step) begin
            if (slot.src == SRC_STAT) stc <= slot.rewind ? '0 : stc + 1'b1;
            if (ptr == LAST) running <= 1'b0;
            else             ptr     <= ptr + 1'b1;
         end
      end
   end

   assign done = done_q;

   // R8: the program pointer does not move while waiting for a base
   assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (stall && !start) |=> ptr == $past(ptr));

   // R9: completion is a single-cycle pulse
   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

endmodule

// File: rtl/mem_access_seq.sv
module mem_access_seq
   import mas_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int LADDR_W    = 10,
   parameter int NBANK      = 4,
   parameter int BANK_DEPTH = 256,
   parameter int IDX_W      = 4,
   parameter int ROW_STRIDE = 64,
   parameter bit SHIFT_EN   = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [DATA_W-1:0]  dp_wdata,
   input  logic               cond_ld,
   input  logic [LADDR_W-1:0] base_in,
   input  logic               base_valid,
   output logic [NBANK-1:0]   bank_act,
   output logic               stall,
   output logic               done,
   output logic               rd_valid,
   output logic [DATA_W-1:0]  rd_data
);

   localparam int BANK_W  = (NBANK > 1) ? $clog2(NBANK) : 1;
   localparam int PADDR_W = $clog2(BANK_DEPTH);

   generate
      if (NBANK * BANK_DEPTH != 2 ** LADDR_W) begin : g_bad_size
         $error("banks must cover the logical address space exactly");
      end
      if (LADDR_W >= DATA_W) begin : g_bad_width
         $error("address width must be narrower than data width");
      end
      if (IDX_W >= LADDR_W) begin : g_bad_idx
         $error("translation index must leave an offset field");
      end
   endgenerate

   slot_t              slot;
   logic               step;
   logic               issue;
   logic               issue_we;
   logic [LADDR_W-1:0] laddr;
   logic [LADDR_W-1:0] base_q;
   logic [LADDR_W-1:0] dyn_addr;
   logic [BANK_W-1:0]  bank;
   logic [PADDR_W-1:0] paddr;

   mas_sched_ctrl #(
      .LADDR_W (LADDR_W),
      .NSLOT   (PROG_LEN)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .cond_ld    (cond_ld),
      .cond_bit   (dp_wdata[0]),
      .base_in    (base_in),
      .base_valid (base_valid),
      .dyn_addr   (dyn_addr),
      .slot       (slot),
      .step       (step),
      .issue      (issue),
      .issue_we   (issue_we),
      .laddr      (laddr),
      .base_q     (base_q),
      .stall      (stall),
      .done       (done)
   );

   mas_addr_alu #(
      .LADDR_W  (LADDR_W),
      .STRIDE   (ROW_STRIDE),
      .SHIFT_EN (SHIFT_EN)
   ) u_alu (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (start),
      .step     (step),
      .op       (slot.alu),
      .cur_addr (laddr),
      .base     (base_q),
      .dyn      (dyn_addr)
   );

   mas_xlat #(
      .LADDR_W    (LADDR_W),
      .IDX_W      (IDX_W),
      .NBANK      (NBANK),
      .BANK_DEPTH (BANK_DEPTH)
   ) u_xlat (
      .laddr (laddr),
      .bank  (bank),
      .paddr (paddr)
   );

   mas_bank_array #(
      .NBANK      (NBANK),
      .BANK_DEPTH (BANK_DEPTH),
      .DATA_W     (DATA_W)
   ) u_banks (
      .clk      (clk),
      .rst_n    (rst_n),
      .issue    (issue),
      .we       (issue_we),
      .bank     (bank),
      .paddr    (paddr),
      .wdata    (dp_wdata),
      .bank_en  (bank_act),
      .rd_valid (rd_valid),
      .rd_data  (rd_data)
   );

   // R8: no bank sees a command while the program waits for a base
   assert_stall_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> bank_act == '0);

   // R6: returned data always follows a bank command one cycle earlier
   assert_rd_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(|bank_act));

endmodule

// File: tb/test_mem_access_seq.sv
module test_mem_access_seq;

   localparam int DW    = 16;
   localparam int AW    = 10;
   localparam int NB    = 4;
   localparam int NCYC  = 28;
   localparam int NCHK  = 38;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [DW-1:0] dp_wdata = '0;
   logic          cond_ld = 1'b0;
   logic [AW-1:0] base_in = '0;
   logic          base_valid = 1'b0;
   logic [NB-1:0] bank_act;
   logic          stall;
   logic          done;
   logic          rd_valid;
   logic [DW-1:0] rd_data;

   always #10 clk = ~clk;

   mem_access_seq i_mem_access_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .dp_wdata   (dp_wdata),
      .cond_ld    (cond_ld),
      .base_in    (base_in),
      .base_valid (base_valid),
      .bank_act   (bank_act),
      .stall      (stall),
      .done       (done),
      .rd_valid   (rd_valid),
      .rd_data    (rd_data)
   );

   int n_run  = 0;
   int n_fail = 0;

   logic [DW-1:0] cap_d  [3][NCYC];
   logic          cap_v  [3][NCYC];
   logic [NB-1:0] cap_a  [3][NCYC];
   logic          cap_s  [3][NCYC];
   logic          cap_dn [3][NCYC];

   // row = {run, cycle, kind, expected, requirement}
   // kind: 0 read word, 1 no read, 2 bank_act, 3 stall, 4 done
   localparam logic [29:0] CHK [NCHK] = '{
      {2'd0, 5'd1,  3'd2, 16'h0001, 4'd4},   // R4 address 0 -> bank 0
      {2'd0, 5'd3,  3'd2, 16'h0000, 4'd5},   // R5 gated write, no bank
      {2'd0, 5'd6,  3'd0, 16'hA001, 4'd6},   // R6 read one cycle later
      {2'd0, 5'd7,  3'd0, 16'hA002, 4'd3},   // R3 counter step
      {2'd0, 5'd8,  3'd1, 16'h0000, 4'd5},   // R5 gated read, no strobe
      {2'd0, 5'd9,  3'd0, 16'hA004, 4'd10},  // R10 slot order
      {2'd0, 5'd10, 3'd3, 16'h0001, 4'd8},   // R8 waiting for base
      {2'd0, 5'd10, 3'd2, 16'h0000, 4'd8},   // R8 banks quiet
      {2'd0, 5'd12, 3'd3, 16'h0001, 4'd8},   // R8 still waiting
      {2'd0, 5'd13, 3'd3, 16'h0000, 4'd8},   // R8 resumes after base
      {2'd0, 5'd13, 3'd2, 16'h0008, 4'd4},   // R4 448 -> bank 3
      {2'd0, 5'd15, 3'd2, 16'h0001, 4'd7},   // R7 513 -> bank 0
      {2'd0, 5'd18, 3'd0, 16'hA00D, 4'd7},   // R7 block walk
      {2'd0, 5'd19, 3'd0, 16'hA00E, 4'd7},
      {2'd0, 5'd20, 3'd0, 16'hA00F, 4'd7},
      {2'd0, 5'd21, 3'd0, 16'hA010, 4'd7},
      {2'd0, 5'd22, 3'd1, 16'h0000, 4'd5},   // R5 last slot gated
      {2'd0, 5'd21, 3'd4, 16'h0000, 4'd9},   // R9 not yet done
      {2'd0, 5'd22, 3'd4, 16'h0001, 4'd9},   // R9 done pulse
      {2'd0, 5'd23, 3'd4, 16'h0000, 4'd9},   // R9 single cycle
      {2'd0, 5'd24, 3'd2, 16'h0000, 4'd9},   // R9 idle afterwards
      {2'd1, 5'd6,  3'd0, 16'hB001, 4'd3},   // R3
      {2'd1, 5'd8,  3'd0, 16'hB003, 4'd5},   // R5 flag set, access runs
      {2'd1, 5'd9,  3'd0, 16'hB004, 4'd3},   // R3
      {2'd1, 5'd9,  3'd3, 16'h0000, 4'd8},   // R8 early base, no stall
      {2'd1, 5'd9,  3'd2, 16'h0008, 4'd4},   // R4 960 -> bank 3
      {2'd1, 5'd11, 3'd2, 16'h0001, 4'd7},   // R7 1025 wraps to 1
      {2'd1, 5'd14, 3'd0, 16'hB009, 4'd7},   // R7
      {2'd1, 5'd15, 3'd0, 16'hB00A, 4'd7},
      {2'd1, 5'd16, 3'd0, 16'hB00B, 4'd7},
      {2'd1, 5'd17, 3'd0, 16'hB00C, 4'd7},
      {2'd1, 5'd18, 3'd0, 16'hB00C, 4'd7},   // R7 shift result 0
      {2'd1, 5'd18, 3'd4, 16'h0001, 4'd9},   // R9
      {2'd2, 5'd1,  3'd2, 16'h0001, 4'd2},   // R2 slot 0 after start
      {2'd2, 5'd7,  3'd0, 16'hC002, 4'd2},   // R2 counter restarted
      {2'd2, 5'd8,  3'd1, 16'h0000, 4'd2},   // R2 flag cleared
      {2'd2, 5'd10, 3'd3, 16'h0001, 4'd2},   // R2 held base cleared
      {2'd2, 5'd22, 3'd4, 16'h0001, 4'd2}    // R2 full rerun
   };

   task automatic check(input string what, input int req,
                        input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic run(input int r, input logic [DW-1:0] dbase,
                      input logic send_cond, input int base_k,
                      input logic [AW-1:0] base_val);
      for (int k = 0; k < NCYC; k++) begin
         @(negedge clk);
         cap_d[r][k]  = rd_data;
         cap_v[r][k]  = rd_valid;
         cap_a[r][k]  = bank_act;
         cap_s[r][k]  = stall;
         cap_dn[r][k] = done;
         start      = (k == 0);
         dp_wdata   = dbase + DW'(k);
         cond_ld    = send_cond && (k == 1);
         base_valid = (k == base_k);
         base_in    = base_val;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL R9 watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 outputs quiet in reset
      check("bank_act in reset", 1, 32'(bank_act), 32'h0);
      check("rd_valid in reset", 1, 32'(rd_valid), 32'h0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      // R1 outputs quiet after reset, before start
      check("stall after reset", 1, 32'(stall), 32'h0);
      check("done after reset", 1, 32'(done), 32'h0);

      run(0, 16'hA000, 1'b0, 12, 10'd448);
      run(1, 16'hB000, 1'b1, 2,  10'd960);
      run(2, 16'hC000, 1'b0, 12, 10'd448);

      for (int i = 0; i < NCHK; i++) begin
         int          r;
         int          k;
         int          kind;
         int          req;
         logic [15:0] exp;
         r    = int'(CHK[i][29:28]);
         k    = int'(CHK[i][27:23]);
         kind = int'(CHK[i][22:20]);
         exp  = CHK[i][19:4];
         req  = int'(CHK[i][3:0]);
         case (kind)
            0: check($sformatf("run %0d cyc %0d read word", r, k), req,
                     {15'd0, cap_v[r][k], cap_d[r][k]}, {15'd0, 1'b1, exp});
            1: check($sformatf("run %0d cyc %0d no read", r, k), req,
                     32'(cap_v[r][k]), 32'h0);
            2: check($sformatf("run %0d cyc %0d bank_act", r, k), req,
                     32'(cap_a[r][k]), 32'(exp));
            3: check($sformatf("run %0d cyc %0d stall", r, k), req,
                     32'(cap_s[r][k]), 32'(exp));
            default: check($sformatf("run %0d cyc %0d done", r, k), req,
                     32'(cap_dn[r][k]), 32'(exp));
         endcase
      end

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule